// File: doc/BRIEF.md
# Four-Channel PWM Controller with Buffered Updates

This block generates four independent pulse-width modulated outputs from one clock. Software programs each channel through a flat register port: a mode word (clock prescale exponent, output polarity and the target of buffered updates), a 16-bit period and a 16-bit inactive count. It starts and stops channels through separate set-only and clear-only registers, and reads back which channels are running from a status word.

Each running channel counts prescaled ticks from 0 to period-1 and wraps. The output stays at its inactive level while the count is below the programmed inactive count, and moves to its active level for the rest of the period. The inactive count and the period can only be written directly while the channel is stopped. A running channel is retuned through its buffered-update register instead. That value waits and is copied into either the inactive count or the period at the wrap that closes the current period. A waveform therefore never switches settings partway through a period.

Top module: `pwm_quad`

## Requirements
- R1: After reset the status word reads 0, every channel register reads 0 and all four outputs are low.
- R2: A write to address 0x004 starts each channel n whose data bit n is 1 and leaves all other channels unchanged. The status word at 0x00C shows running channels in bits 3:0, and reads 0xF when all four run.
- R3: A write to address 0x008 stops each channel n whose data bit n is 1 and leaves all other channels unchanged.
- R4: The registers of channel n sit at base 0x200 + 0x20*n, with the mode word at +0x00, the inactive count at +0x04, the period at +0x08 and the update register at +0x10. Reads of any other address return 0.
- R5: In the mode word, bits 3:0 hold the prescale exponent, bit 9 holds the polarity and bit 10 holds the update target. All other bits read back as 0.
- R6: The inactive count, the period and the update register keep only data bits 15:0. Bits 31:16 read back as 0.
- R7: Let k be the number of rising edges since the edge that started a channel, p = min(exponent, 10) and P the period. The channel count is floor(k / 2^p) mod P. The output is active while that count is greater than or equal to the inactive count.
- R8: The active level is high when polarity is 0 and low when polarity is 1. A stopped channel drives the opposite, inactive level.
- R9: Writes to the inactive count or the period take effect at once while the channel is stopped. They have no effect while it runs.
- R10: While a channel runs, an update-register write is held. At the next wrap it is copied into the period if mode bit 10 is 1, or into the inactive count if bit 10 is 0. While the channel is stopped, the copy happens on the write itself.
- R11: Stopping a channel clears its count, so a channel that is started again begins at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data, combinational from addr |
| pwm_out | output | 4 | Channel outputs, bit n is channel n |

## Verification
Read data is combinational, so the bench samples it one time unit after it sets the address, between clock edges. Register writes, and the start and stop of a channel, show on the outputs from the first falling edge after the rising edge that captures the write. The bench writes on one falling edge and samples from the next, and it numbers waveform cycles from the start edge, so each expected output comes from the R7 formula at that exact edge count. Buffered updates are written in the middle of a period. The bench checks the old setting through the last cycle of that period and the new one from the first cycle after the wrap.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned PRE_W     = 4;
  localparam int unsigned OFF_EN    = 'h004;
  localparam int unsigned OFF_DIS   = 'h008;
  localparam int unsigned OFF_STAT  = 'h00C;
  localparam int unsigned CH_BASE   = 'h200;
  localparam int unsigned CH_STRIDE = 'h020;
  localparam int unsigned CH_MODE   = 'h00;
  localparam int unsigned CH_IDLE   = 'h04;
  localparam int unsigned CH_PER    = 'h08;
  localparam int unsigned CH_UPD    = 'h10;

  typedef struct packed {
    logic             to_per;
    logic             inv;
    logic [PRE_W-1:0] pre;
  } mode_t;

  function automatic logic [BUS_W-1:0] mode_to_bus(mode_t m);
    logic [BUS_W-1:0] r;
    r           = '0;
    r[PRE_W-1:0] = m.pre;
    r[9]        = m.inv;
    r[10]       = m.to_per;
    return r;
  endfunction

  function automatic mode_t bus_to_mode(logic [BUS_W-1:0] w);
    mode_t m;
    m.pre    = w[PRE_W-1:0];
    m.inv    = w[9];
    m.to_per = w[10];
    return m;
  endfunction
endpackage

// File: rtl/pwm_quad_div.sv
module pwm_quad_div #(
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int unsigned CNT_W = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [PRE_W-1:0] eff;

  always_comb begin
    eff  = (pre > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre;
    lim  = ~({CNT_W{1'b1}} << eff);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the divider stays cleared while the channel is stopped
  assert_div_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int unsigned DAT_W   = 16,
  parameter int unsigned PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_mode,
  input  logic             wr_idle,
  input  logic             wr_per,
  input  logic             wr_upd,
  input  mode_t            wmode,
  input  logic [DAT_W-1:0] wdat,
  output mode_t            mode_o,
  output logic [DAT_W-1:0] idle_o,
  output logic [DAT_W-1:0] per_o,
  output logic [DAT_W-1:0] upd_o,
  output logic             pwm_o
);
  mode_t            mode_q, mode_d;
  logic [DAT_W-1:0] idle_q, idle_d, per_q, per_d, upd_q, upd_d, cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             tick, wrap;

  pwm_quad_div #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .pre  (mode_q.pre),
    .tick (tick)
  );

  assign wrap = tick && ((per_q == '0) || (cnt_q == per_q - 1'b1));

  always_comb begin
    mode_d = mode_q;
    idle_d = idle_q;
    per_d  = per_q;
    upd_d  = upd_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (wr_mode) mode_d = wmode;
    if (!run) begin
      cnt_d  = '0;
      pend_d = 1'b0;
      if (wr_idle) idle_d = wdat;
      if (wr_per)  per_d  = wdat;
      if (wr_upd) begin
        upd_d = wdat;
        if (mode_q.to_per) per_d  = wdat;
        else               idle_d = wdat;
      end
    end else begin
      if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
      if (wrap && pend_q) begin
        pend_d = 1'b0;
        if (mode_q.to_per) per_d  = upd_q;
        else               idle_d = upd_q;
      end
      if (wr_upd) begin
        upd_d  = wdat;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      idle_q <= '0;
      per_q  <= '0;
      upd_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      idle_q <= idle_d;
      per_q  <= per_d;
      upd_q  <= upd_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign mode_o = mode_q;
  assign idle_o = idle_q;
  assign per_o  = per_q;
  assign upd_o  = upd_q;
  assign pwm_o  = mode_q.inv ^ (run && (cnt_q >= idle_q));

  // R7: a running count never reaches the period
  assert_cnt_below_per_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (per_q != '0)) |-> (cnt_q < per_q));
  // R10: settings of a running channel change only at a wrap
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(idle_q));
  assert_per_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(per_q));
  assert_pend_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap && pend_q && !wr_upd) |=> !pend_q);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DAT_W   = 16,
  parameter int unsigned PRE_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              wr_en,
  output logic [BUS_W-1:0]  rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int unsigned OFF_W = $clog2(CH_STRIDE);

  logic [NUM_CH-1:0] run_q, run_d, ch_hit;
  logic              wr_on, wr_off;
  mode_t             ch_mode [NUM_CH];
  logic [DAT_W-1:0]  ch_idle [NUM_CH];
  logic [DAT_W-1:0]  ch_per  [NUM_CH];
  logic [DAT_W-1:0]  ch_upd  [NUM_CH];
  logic [OFF_W-1:0]  off;
  logic              unused_hi;

  assign unused_hi = ^wdata[BUS_W-1:DAT_W];
  assign off       = addr[OFF_W-1:0];
  assign wr_on     = wr_en && (addr == ADDR_W'(OFF_EN));
  assign wr_off    = wr_en && (addr == ADDR_W'(OFF_DIS));

  always_comb begin
    run_d = run_q;
    if (wr_on)  run_d = run_q | wdata[NUM_CH-1:0];
    if (wr_off) run_d = run_q & ~wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE_I = ADDR_W'(CH_BASE + i * CH_STRIDE);
    assign ch_hit[i] = (addr[ADDR_W-1:OFF_W] == BASE_I[ADDR_W-1:OFF_W]);

    pwm_quad_chan #(.DAT_W(DAT_W), .PRE_MAX(PRE_MAX)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[i]),
      .wr_mode(wr_en && ch_hit[i] && (off == OFF_W'(CH_MODE))),
      .wr_idle(wr_en && ch_hit[i] && (off == OFF_W'(CH_IDLE))),
      .wr_per (wr_en && ch_hit[i] && (off == OFF_W'(CH_PER))),
      .wr_upd (wr_en && ch_hit[i] && (off == OFF_W'(CH_UPD))),
      .wmode  (bus_to_mode(wdata)),
      .wdat   (wdata[DAT_W-1:0]),
      .mode_o (ch_mode[i]),
      .idle_o (ch_idle[i]),
      .per_o  (ch_per[i]),
      .upd_o  (ch_upd[i]),
      .pwm_o  (pwm_out[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_STAT)) rdata[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        if (off == OFF_W'(CH_MODE)) rdata = mode_to_bus(ch_mode[i]);
        if (off == OFF_W'(CH_IDLE)) rdata = BUS_W'(ch_idle[i]);
        if (off == OFF_W'(CH_PER))  rdata = BUS_W'(ch_per[i]);
        if (off == OFF_W'(CH_UPD))  rdata = BUS_W'(ch_upd[i]);
      end
    end
  end

  // R2: every set bit of a start write is running afterwards
  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_on |=> ((run_q & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));
  // R3: every set bit of a stop write is stopped afterwards
  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> ((run_q & $past(wdata[NUM_CH-1:0])) == '0));
  // R2: without a start or stop write the running set holds
  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_on || wr_off) |=> $stable(run_q));
endmodule

// File: tb/pwm_quad_tb.sv
`timescale 1ns/1ps
module pwm_quad_tb;
  logic        clk, rst_n, wr_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, rv;
  logic [3:0]  pwm_out;
  int          checks, errors;
  bit          done;

  pwm_quad u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {exponent[36:33], polarity[32], inactive count[31:16], period[15:0]}
  localparam logic [36:0] VEC [6] = '{
    {4'd0, 1'b0, 16'd3, 16'd8},
    {4'd1, 1'b0, 16'd1, 16'd5},
    {4'd2, 1'b1, 16'd2, 16'd4},
    {4'd0, 1'b1, 16'd0, 16'd6},
    {4'd0, 1'b0, 16'd9, 16'd6},
    {4'd3, 1'b0, 16'd5, 16'd7}
  };

  function automatic logic [11:0] cb(int ch, int o);
    return 12'(12'h200 + ch * 32 + o);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic wave(int k, int p, int pol, int idl, int per);
    int c;
    c = (k >> p) % per;
    return 1'(pol) ^ (c >= idl);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(12'h00C, rv); chk("R1 status", rv, 0);
    chk("R1 outputs", 32'(pwm_out), 0);
    for (int o = 0; o < 20; o += 4) begin
      rd(cb(3, o), rv); chk("R1 ch3 reg", rv, 0);
    end

    // R5, R8: mode fields and idle level under inverted polarity
    wr(cb(1, 0), 32'hFFFF_FFFF);
    rd(cb(1, 0), rv); chk("R5 mode readback", rv, 32'h0000_060F);
    chk("R8 idle inverted", 32'(pwm_out[1]), 1);
    wr(cb(1, 0), 32'h0);
    chk("R8 idle normal", 32'(pwm_out[1]), 0);

    // R6: upper half dropped
    wr(cb(2, 4), 32'hABCD_1234);
    rd(cb(2, 4), rv); chk("R6 inactive count", rv, 32'h1234);
    wr(cb(2, 8), 32'h5555_0007);
    rd(cb(2, 8), rv); chk("R6 period", rv, 32'h7);

    // R2, R3: start and stop set semantics
    wr(12'h004, 32'h5); rd(12'h00C, rv); chk("R2 start 0101", rv, 32'h5);
    wr(12'h004, 32'hA); rd(12'h00C, rv); chk("R2 all running", rv, 32'hF);
    wr(12'h004, 32'h0); rd(12'h00C, rv); chk("R2 zero bits", rv, 32'hF);
    wr(12'h008, 32'h2); rd(12'h00C, rv); chk("R3 stop ch1", rv, 32'hD);
    wr(12'h008, 32'h0); rd(12'h00C, rv); chk("R3 zero bits", rv, 32'hD);
    wr(12'h008, 32'hF); rd(12'h00C, rv); chk("R3 stop all", rv, 32'h0);

    // R4: unmapped addresses
    wr(12'h100, 32'hFFFF);
    rd(12'h100, rv); chk("R4 unmapped", rv, 0);
    rd(cb(0, 12), rv); chk("R4 channel hole", rv, 0);

    // R7, R8: waveform table
    for (int vi = 0; vi < 6; vi++) begin
      automatic int ch  = vi % 4;
      automatic int p   = int'(VEC[vi][36:33]);
      automatic int pol = int'(VEC[vi][32]);
      automatic int idl = int'(VEC[vi][31:16]);
      automatic int per = int'(VEC[vi][15:0]);
      wr(cb(ch, 0), 32'(p) | (32'(pol) << 9));
      wr(cb(ch, 4), 32'(idl));
      wr(cb(ch, 8), 32'(per));
      wr(12'h004, 32'(1 << ch));
      for (int k = 0; k < 2 * (1 << p) * per; k++) begin
        chk("R7 waveform", 32'(pwm_out[ch]), 32'(wave(k, p, pol, idl, per)));
        @(negedge clk);
      end
      wr(12'h008, 32'(1 << ch));
      chk("R8 stopped level", 32'(pwm_out[ch]), 32'(pol));
      wr(cb(ch, 0), 32'h0);
    end

    // R10: buffered inactive-count update on channel 0
    wr(cb(0, 4), 32'd4);
    wr(cb(0, 8), 32'd8);
    wr(12'h004, 32'h1);
    wr(cb(0, 16), 32'd6);
    for (int k = 2; k < 16; k++) begin
      if (k < 8) chk("R10 old inactive", 32'(pwm_out[0]), 32'(wave(k, 0, 0, 4, 8)));
      else       chk("R10 new inactive", 32'(pwm_out[0]), 32'(wave(k - 8, 0, 0, 6, 8)));
      @(negedge clk);
    end
    rd(cb(0, 4), rv); chk("R10 inactive loaded", rv, 32'd6);

    // R10: buffered period update
    wr(12'h008, 32'h1);
    wr(cb(0, 4), 32'd2);
    wr(cb(0, 0), 32'h400);
    wr(12'h004, 32'h1);
    wr(cb(0, 16), 32'd4);
    for (int k = 2; k < 16; k++) begin
      if (k < 8) chk("R10 old period", 32'(pwm_out[0]), 32'(wave(k, 0, 0, 2, 8)));
      else       chk("R10 new period", 32'(pwm_out[0]), 32'(wave(k - 8, 0, 0, 2, 4)));
      @(negedge clk);
    end
    rd(cb(0, 8), rv); chk("R10 period loaded", rv, 32'd4);

    // R9: direct writes ignored while running
    wr(cb(0, 4), 32'd1);
    rd(cb(0, 4), rv); chk("R9 inactive held", rv, 32'd2);
    wr(cb(0, 8), 32'd9);
    rd(cb(0, 8), rv); chk("R9 period held", rv, 32'd4);

    // R11: restart from count 0
    wr(12'h008, 32'h1);
    chk("R11 stopped low", 32'(pwm_out[0]), 0);
    wr(12'h004, 32'h1);
    for (int k = 0; k < 4; k++) begin
      chk("R11 restart", 32'(pwm_out[0]), 32'(wave(k, 0, 0, 2, 4)));
      @(negedge clk);
    end
    wr(12'h008, 32'h1);

    // R10: stopped channel copies update on the write
    wr(cb(2, 0), 32'h400);
    wr(cb(2, 16), 32'd9);
    rd(cb(2, 8), rv); chk("R10 direct period", rv, 32'd9);
    wr(cb(2, 0), 32'h0);
    wr(cb(2, 16), 32'h0001_2345);
    rd(cb(2, 4), rv); chk("R10 direct inactive", rv, 32'h2345);
    rd(cb(2, 16), rv); chk("R6 update reg", rv, 32'h2345);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule